// File: doc/BRIEF.md
# Supply Monitor Command and Fault Register File

This block is the register file of a six-channel supply monitor and sequencer. A host reaches it over a plain synchronous register bus with an address, write data, a write strobe, a read strobe and read data. It holds three byte-wide registers. A command register takes one-hot software commands. A fault register takes a snapshot of the six channel flags when an interrupt event occurs. A status register always shows the live flags.

The block merges the software command bits with two board pins: an active-low force-off pin and a watchdog-inhibit pin. It turns the result into the signals the rest of the monitor uses. These are one-cycle power-up and power-down requests to the sequencer, a gate on the six power-up enables, and a hold signal that keeps both watchdog timers cleared and blocks interrupt capture. The comparators, the sequencer, the timers and the serial physical layer live elsewhere.

Top module: `supply_cmd_regs`

## Requirements
- R1: After reset the command and fault registers read 0x00, no request pulses are active, `wdHold` is 0, and `pupEn` passes `seqEn` through while `forceOffN` is high.
- R2: Writing 0x80 to address 0x0F raises `pwrUpReq` for exactly the one cycle after the write edge. Writing 0x40 does the same on `pwrDownReq`. Both bits clear themselves, so a later read of 0x0F shows bits 7 and 6 as 0.
- R3: The force-off command is bit 5, written as 0x20. It stays set until overwritten. While it is set or `forceOffN` is low, `pupEn` is 0; otherwise `pupEn` equals `seqEn`.
- R4: The watchdog command is bit 4, written as 0x10. It stays set until overwritten. `wdHold` is 1 while this bit or the `wdInhibit` pin is 1.
- R5: A write to 0x0F that has more than one of bits 7..4 set, or has any of bits 3..0 set, is ignored. The command register keeps its value and no request pulse occurs.
- R6: Writing 0x00 to 0x0F clears the force-off and watchdog bits.
- R7: A read of address 0x0E returns the live `chanFlags` in bits 5..0, where bit 5 is channel A and bit 0 is channel F. Bits 7..6 read 0.
- R8: When `irqEvent` is high and `wdHold` is low at a clock edge, the fault register at 0x0D loads `chanFlags`. It holds that value until the next such event.
- R9: An `irqEvent` that arrives while `wdHold` is high leaves the fault register unchanged.
- R10: Read data appears on `regRdata` in the cycle after `regRe`. Reads of any address other than 0x0D, 0x0E or 0x0F return 0x00.
- R11: A read of 0x0F returns the stored command bits in 7..4 and 0 in bits 3..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| regAddr | input | 8 | Register address |
| regWdata | input | 8 | Write data |
| regWe | input | 1 | Write strobe |
| regRe | input | 1 | Read strobe |
| regRdata | output | 8 | Read data, valid the cycle after `regRe` |
| chanFlags | input | 6 | Live under/over-voltage flags, bit 5 is channel A |
| irqEvent | input | 1 | Interrupt event from the monitor |
| forceOffN | input | 1 | Active-low force-off pin |
| wdInhibit | input | 1 | Watchdog-inhibit pin |
| seqEn | input | 6 | Power-up enables from the sequencer |
| pupEn | output | 6 | Gated power-up enables |
| pwrUpReq | output | 1 | One-cycle power-up request |
| pwrDownReq | output | 1 | One-cycle power-down request |
| wdHold | output | 1 | Holds the watchdog timers clear and blocks interrupts |

## Verification
The command register is tried with each legal one-hot value. It is also tried with illegal values that have two command bits set, a low nibble bit set, or both request bits set. This separates a correct legality check from one that tests only the upper nibble or only the population count. The force-off and watchdog paths are each driven once from the register and once from the pin, which shows that the two sources are ORed. Interrupt events are applied with hold off and with hold on, the hold coming from the command and from the pin. Between events the channel flags change, so a capture that is missing or follows the live flags shows up as a value that differs from the status read.

// File: rtl/supply_cmd_pkg.sv
package supply_cmd_pkg;
  localparam int DATA_W = 8;
  localparam int CMD_W  = 4;
  localparam logic [7:0] ADDR_FAULT  = 8'h0D;
  localparam logic [7:0] ADDR_STATUS = 8'h0E;
  localparam logic [7:0] ADDR_CMD    = 8'h0F;
  // Index into the stored command nibble (write data bits 7..4)
  localparam int CIDX_UP    = 3;
  localparam int CIDX_DOWN  = 2;
  localparam int CIDX_FORCE = 1;
  localparam int CIDX_WD    = 0;

  typedef enum logic [1:0] {SEL_NONE, SEL_FAULT, SEL_STATUS, SEL_CMD} rdSel_e;

  typedef struct packed {
    logic   cmdLoad;
    logic   faultLoad;
    logic   rdLoad;
    rdSel_e rdSel;
  } strobes_t;
endpackage

// File: rtl/supply_cmd_ctrl.sv
module supply_cmd_ctrl
  import supply_cmd_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              regWe,
  input  logic              regRe,
  input  logic              irqEvent,
  input  logic              holdActive,
  output strobes_t          strobes
);
  localparam int LOW_W = DATA_W - CMD_W;

  logic [CMD_W-1:0] cmdField;
  logic             legalCmd;
  logic [2:0]       setCount;

  assign cmdField = regWdata[DATA_W-1:LOW_W];

  always_comb begin
    setCount = '0;
    for (int i = 0; i < CMD_W; i++) setCount = setCount + 3'(cmdField[i]);
  end

  assign legalCmd = (setCount <= 3'd1) && (regWdata[LOW_W-1:0] == '0);

  always_comb begin
    strobes.cmdLoad   = regWe && (regAddr == ADDR_W'(ADDR_CMD)) && legalCmd;
    strobes.faultLoad = irqEvent && !holdActive;
    strobes.rdLoad    = regRe;
    if (regAddr == ADDR_W'(ADDR_FAULT))       strobes.rdSel = SEL_FAULT;
    else if (regAddr == ADDR_W'(ADDR_STATUS)) strobes.rdSel = SEL_STATUS;
    else if (regAddr == ADDR_W'(ADDR_CMD))    strobes.rdSel = SEL_CMD;
    else                                      strobes.rdSel = SEL_NONE;
  end
endmodule

// File: rtl/supply_cmd_dp.sv
module supply_cmd_dp
  import supply_cmd_pkg::*;
#(
  parameter int CHAN_N = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strobes,
  input  logic [DATA_W-1:0] regWdata,
  input  logic [CHAN_N-1:0] chanFlags,
  output logic [CMD_W-1:0]  cmdQ,
  output logic [CHAN_N-1:0] faultQ,
  output logic [DATA_W-1:0] rdataQ
);
  localparam int PAD_W = DATA_W - CHAN_N;

  logic [DATA_W-1:0] rdNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdQ <= '0;
    end else if (strobes.cmdLoad) begin
      cmdQ <= regWdata[DATA_W-1:DATA_W-CMD_W];
    end else begin
      cmdQ[CIDX_UP]   <= 1'b0;
      cmdQ[CIDX_DOWN] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  faultQ <= '0;
    else if (strobes.faultLoad) faultQ <= chanFlags;
  end

  always_comb begin
    unique case (strobes.rdSel)
      SEL_FAULT:  rdNext = {{PAD_W{1'b0}}, faultQ};
      SEL_STATUS: rdNext = {{PAD_W{1'b0}}, chanFlags};
      SEL_CMD:    rdNext = {cmdQ, {(DATA_W-CMD_W){1'b0}}};
      default:    rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               rdataQ <= '0;
    else if (strobes.rdLoad) rdataQ <= rdNext;
  end
endmodule

// File: rtl/supply_cmd_regs.sv
module supply_cmd_regs
  import supply_cmd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CHAN_N = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWdata,
  input  logic              regWe,
  input  logic              regRe,
  output logic [7:0]        regRdata,
  input  logic [CHAN_N-1:0] chanFlags,
  input  logic              irqEvent,
  input  logic              forceOffN,
  input  logic              wdInhibit,
  input  logic [CHAN_N-1:0] seqEn,
  output logic [CHAN_N-1:0] pupEn,
  output logic              pwrUpReq,
  output logic              pwrDownReq,
  output logic              wdHold
);
  strobes_t          strobes;
  logic [CMD_W-1:0]  cmdQ;
  logic [CHAN_N-1:0] faultQ;
  logic              shutdown;

  assign shutdown   = cmdQ[CIDX_FORCE] | ~forceOffN;
  assign wdHold     = cmdQ[CIDX_WD] | wdInhibit;
  assign pupEn      = shutdown ? '0 : seqEn;
  assign pwrUpReq   = cmdQ[CIDX_UP];
  assign pwrDownReq = cmdQ[CIDX_DOWN];

  supply_cmd_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .regAddr(regAddr), .regWdata(regWdata), .regWe(regWe), .regRe(regRe),
    .irqEvent(irqEvent), .holdActive(wdHold), .strobes(strobes)
  );

  supply_cmd_dp #(.CHAN_N(CHAN_N)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .regWdata(regWdata),
    .chanFlags(chanFlags), .cmdQ(cmdQ), .faultQ(faultQ), .rdataQ(regRdata)
  );
endmodule

// File: rtl/supply_cmd_regs_chk.sv
module supply_cmd_regs_chk #(
  parameter int ADDR_W = 8,
  parameter int CHAN_N = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic [7:0]        regWdata,
  input logic              regWe,
  input logic              regRe,
  input logic [7:0]        regRdata,
  input logic [CHAN_N-1:0] chanFlags,
  input logic              irqEvent,
  input logic              forceOffN,
  input logic [CHAN_N-1:0] pupEn,
  input logic              pwrUpReq,
  input logic              pwrDownReq,
  input logic              wdHold,
  input logic [CHAN_N-1:0] faultQ
);
  logic badCmdWrite;
  logic unmappedRead;
  assign badCmdWrite = regWe && (regAddr == ADDR_W'(8'h0F)) &&
                       (($countones(regWdata[7:4]) > 1) || (regWdata[3:0] != 4'h0));
  assign unmappedRead = regRe && (regAddr != ADDR_W'(8'h0D)) &&
                        (regAddr != ADDR_W'(8'h0E)) && (regAddr != ADDR_W'(8'h0F));

  p_up_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    pwrUpReq |=> !pwrUpReq);
  p_down_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    pwrDownReq |=> !pwrDownReq);
  p_req_exclusive_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({pwrUpReq, pwrDownReq}));
  p_pin_forces_off_r3: assert property (@(posedge clk) disable iff (!rstN)
    !forceOffN |-> (pupEn == '0));
  p_bad_write_no_req_r5: assert property (@(posedge clk) disable iff (!rstN)
    badCmdWrite |=> (!pwrUpReq && !pwrDownReq));
  p_fault_capture_r8: assert property (@(posedge clk) disable iff (!rstN)
    (irqEvent && !wdHold) |=> (faultQ == $past(chanFlags)));
  p_fault_blocked_r9: assert property (@(posedge clk) disable iff (!rstN)
    (irqEvent && wdHold) |=> $stable(faultQ));
  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    unmappedRead |=> (regRdata == 8'h00));
endmodule

bind supply_cmd_regs supply_cmd_regs_chk #(.ADDR_W(ADDR_W), .CHAN_N(CHAN_N)) u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWdata(regWdata), .regWe(regWe),
  .regRe(regRe), .regRdata(regRdata), .chanFlags(chanFlags), .irqEvent(irqEvent),
  .forceOffN(forceOffN), .pupEn(pupEn), .pwrUpReq(pwrUpReq),
  .pwrDownReq(pwrDownReq), .wdHold(wdHold), .faultQ(faultQ)
);

// File: tb/supply_cmd_regs_bench.sv
module supply_cmd_regs_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] regAddr = '0, regWdata = '0, regRdata;
  logic       regWe = 1'b0, regRe = 1'b0;
  logic [5:0] chanFlags = '0, seqEn = 6'h2A, pupEn;
  logic       irqEvent = 1'b0, forceOffN = 1'b1, wdInhibit = 1'b0;
  logic       pwrUpReq, pwrDownReq, wdHold;

  int checks = 0;
  int errors = 0;
  logic [7:0] expQ[$];
  string      tagQ[$];

  always #5 clk = ~clk;

  supply_cmd_regs u_supply_cmd_regs (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWdata(regWdata), .regWe(regWe),
    .regRe(regRe), .regRdata(regRdata), .chanFlags(chanFlags), .irqEvent(irqEvent),
    .forceOffN(forceOffN), .wdInhibit(wdInhibit), .seqEn(seqEn), .pupEn(pupEn),
    .pwrUpReq(pwrUpReq), .pwrDownReq(pwrDownReq), .wdHold(wdHold)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk); regWe = 1'b0;
  endtask

  // Driver: pushes expected read data; the monitor compares it.
  task automatic readReg(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); regAddr = a; regRe = 1'b1;
    expQ.push_back(exp); tagQ.push_back(tag);
    @(negedge clk); regRe = 1'b0;
  endtask

  task automatic pulseIrq(input logic [5:0] flags);
    @(negedge clk); chanFlags = flags; irqEvent = 1'b1;
    @(negedge clk); irqEvent = 1'b0;
  endtask

  // Monitor
  initial begin
    forever begin
      @(posedge clk);
      if (regRe) begin
        @(negedge clk);
        if (expQ.size() > 0) check(regRdata, expQ.pop_front(), tagQ.pop_front());
      end
    end
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check({7'b0, pwrUpReq}, 8'h00, "R1 pwrUpReq");
    check({7'b0, wdHold}, 8'h00, "R1 wdHold");
    check({2'b0, pupEn}, 8'h2A, "R1 pupEn");
    readReg(8'h0F, 8'h00, "R1 cmd");
    readReg(8'h0D, 8'h00, "R1 fault");

    // R2 request pulses
    writeReg(8'h0F, 8'h80);
    check({7'b0, pwrUpReq}, 8'h01, "R2 up pulse");
    @(negedge clk);
    check({7'b0, pwrUpReq}, 8'h00, "R2 up cleared");
    readReg(8'h0F, 8'h00, "R2 up readback");
    writeReg(8'h0F, 8'h40);
    check({6'b0, pwrDownReq, pwrUpReq}, 8'h02, "R2 down pulse");
    @(negedge clk);
    check({7'b0, pwrDownReq}, 8'h00, "R2 down cleared");

    // R3 force off, R11 readback, R6 clear
    writeReg(8'h0F, 8'h20);
    check({2'b0, pupEn}, 8'h00, "R3 cmd force");
    readReg(8'h0F, 8'h20, "R11 force readback");
    writeReg(8'h0F, 8'h00);
    check({2'b0, pupEn}, 8'h2A, "R6 force cleared");
    @(negedge clk); forceOffN = 1'b0;
    #1 check({2'b0, pupEn}, 8'h00, "R3 pin force");
    @(negedge clk); forceOffN = 1'b1;

    // R4 watchdog
    writeReg(8'h0F, 8'h10);
    check({7'b0, wdHold}, 8'h01, "R4 cmd hold");
    readReg(8'h0F, 8'h10, "R11 wd readback");
    writeReg(8'h0F, 8'h00);
    check({7'b0, wdHold}, 8'h00, "R6 hold cleared");
    @(negedge clk); wdInhibit = 1'b1;
    #1 check({7'b0, wdHold}, 8'h01, "R4 pin hold");
    @(negedge clk); wdInhibit = 1'b0;

    // R5 illegal writes
    writeReg(8'h0F, 8'h20);
    writeReg(8'h0F, 8'h30);
    readReg(8'h0F, 8'h20, "R5 two bits");
    writeReg(8'h0F, 8'h21);
    readReg(8'h0F, 8'h20, "R5 low nibble");
    writeReg(8'h0F, 8'h01);
    readReg(8'h0F, 8'h20, "R5 low only");
    writeReg(8'h0F, 8'hC0);
    check({6'b0, pwrDownReq, pwrUpReq}, 8'h00, "R5 no pulse");
    check({2'b0, pupEn}, 8'h00, "R5 force kept");
    writeReg(8'h0F, 8'h00);

    // R7 status
    @(negedge clk); chanFlags = 6'h15;
    readReg(8'h0E, 8'h15, "R7 status a");
    @(negedge clk); chanFlags = 6'h3F;
    readReg(8'h0E, 8'h3F, "R7 status b");

    // R8 capture
    pulseIrq(6'h09);
    @(negedge clk); chanFlags = 6'h00;
    readReg(8'h0D, 8'h09, "R8 fault capture");
    readReg(8'h0E, 8'h00, "R7 status live");

    // R9 blocked
    writeReg(8'h0F, 8'h10);
    pulseIrq(6'h22);
    readReg(8'h0D, 8'h09, "R9 blocked by cmd");
    writeReg(8'h0F, 8'h00);
    @(negedge clk); wdInhibit = 1'b1;
    pulseIrq(6'h30);
    readReg(8'h0D, 8'h09, "R9 blocked by pin");
    @(negedge clk); wdInhibit = 1'b0;
    pulseIrq(6'h22);
    readReg(8'h0D, 8'h22, "R8 recapture");

    // R10 unmapped
    readReg(8'h00, 8'h00, "R10 addr 00");
    readReg(8'h0C, 8'h00, "R10 addr 0C");
    readReg(8'hFF, 8'h00, "R10 addr FF");

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule